// File: doc/BRIEF.md
# Programmable Interval Timer Channel Bank

The block is a bank of identical interval timer channels; three by default. Each channel counts ticks of its clock from the moment a count value is loaded. It drives one output bit whose shape depends on one of six waveform modes: terminal-count flag, one-shot, periodic rate pulse, square wave, and two single-tick strobe flavours.

A host loads a channel by asserting its load strobe for one clock with a mode number and a 16-bit count. The count value zero stands for 65536. Each channel also holds a gate level that the host writes through a gate write strobe. While the gate level is low, that channel's elapsed-tick count holds still.

After reset every channel runs a square wave with period 65536. Channels 0 and 1 come out of reset gated on. Channel 2 comes out of reset gated off.

Top module: `pit_timer`

## Requirements
- R1: A clock edge with a channel's load strobe high stores the mode and the count and sets the elapsed ticks to 0. The output reflects the new settings from the cycle after that edge. A reload while the channel is counting restarts it the same way.
- R2: Mode value 0 (terminal flag) drives the output low while elapsed < count and high once elapsed >= count. It then stays high until the next load.
- R3: Mode value 1 (one-shot) drives the output high while elapsed < count and low once elapsed >= count.
- R4: Mode value 2 (rate pulse) drives the output high only when elapsed is nonzero and an exact multiple of count. The output is low at elapsed 0.
- R5: Mode value 3 (square wave) drives the output high for the first (count+1)>>1 ticks of every count-tick period and low for the remainder. An odd count therefore gets the longer high phase.
- R6: Mode values 4 and 5 (strobes) drive the output high for exactly the one tick where elapsed equals count, and low at every other tick.
- R7: Mode values 6 and 7 behave exactly like mode value 0.
- R8: A loaded count of 0 acts as 65536 in every mode.
- R9: Reset puts every channel in mode 3 with count 65536 and elapsed 0. The output is therefore high for the first 32768 counted ticks and then low.
- R10: Reset sets the gate level to 1 on channels 0 and 1 and to 0 on channel 2. A clock edge with a channel's gate write strobe high stores its gate value. While the stored gate level is 0, elapsed ticks do not advance, though a load still restarts them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Tick clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load | input | CH_N | Per-channel load strobe |
| mode_in | input | 3*CH_N | Per-channel mode number, channel i in bits [3i+2:3i] |
| count_in | input | 16*CH_N | Per-channel count, channel i in bits [16i+15:16i], 0 means 65536 |
| gate_wr | input | CH_N | Per-channel gate write strobe |
| gate_val | input | CH_N | Per-channel gate value stored when gate_wr is high |
| out | output | CH_N | Per-channel timer output |

## Verification
The assertions assume that mode_in and count_in matter only in a cycle where the matching load is high. They also assume the strobe-mode one-tick property applies only while the gate is open, since a closed gate legitimately freezes an active strobe high. The stimulus raises load and gate_wr for single clocks and changes every input at the falling edge. The stimulus keeps all gating changes on channel 2, except for the reset default. This keeps the strobe check on channels whose gate stays open.

// File: rtl/pit_pkg.sv
package pit_pkg;
    localparam int CNT_W  = 16;
    localparam int ELAP_W = CNT_W + 1;
    localparam int MODE_W = 3;

    localparam logic [ELAP_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};
    localparam logic [ELAP_W-1:0] ELAP_MAX = '1;

    typedef enum logic [MODE_W-1:0] {
        M_TERM    = 3'd0,
        M_ONESHOT = 3'd1,
        M_RATE    = 3'd2,
        M_SQUARE  = 3'd3,
        M_SWSTB   = 3'd4,
        M_HWSTB   = 3'd5,
        M_ALT6    = 3'd6,
        M_ALT7    = 3'd7
    } mode_e;

    typedef struct packed {
        mode_e             mode;
        logic [ELAP_W-1:0] cnt;
        logic [ELAP_W-1:0] elap;
        logic [ELAP_W-1:0] phase;
        logic              gate;
    } chan_st_t;
endpackage

// File: rtl/pit_out_decode.sv
module pit_out_decode
    import pit_pkg::*;
(
    input  mode_e             mode,
    input  logic [ELAP_W-1:0] cnt,
    input  logic [ELAP_W-1:0] elap,
    input  logic [ELAP_W-1:0] phase,
    output logic              out
);
    logic [ELAP_W-1:0] half;

    always_comb begin
        half = (cnt + 1'b1) >> 1;
        case (mode)
            M_ONESHOT:        out = (elap < cnt);
            M_RATE:           out = (phase == '0) && (elap != '0);
            M_SQUARE:         out = (phase < half);
            M_SWSTB, M_HWSTB: out = (elap == cnt);
            default:          out = (elap >= cnt);
        endcase
    end
endmodule

// File: rtl/pit_channel.sv
module pit_channel
    import pit_pkg::*;
#(
    parameter logic GATE_RST = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [MODE_W-1:0] mode_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              gate_wr,
    input  logic              gate_val,
    output logic              out
);
    chan_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (gate_wr) begin
            st_d.gate = gate_val;
        end
        if (load) begin
            st_d.mode  = mode_e'(mode_in);
            st_d.cnt   = (count_in == '0) ? FULL_CNT : {1'b0, count_in};
            st_d.elap  = '0;
            st_d.phase = '0;
        end else if (st_q.gate) begin
            st_d.elap  = (st_q.elap == ELAP_MAX) ? st_q.elap : st_q.elap + 1'b1;
            st_d.phase = (st_q.phase == st_q.cnt - 1'b1) ? '0 : st_q.phase + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode  <= M_SQUARE;
            st_q.cnt   <= FULL_CNT;
            st_q.elap  <= '0;
            st_q.phase <= '0;
            st_q.gate  <= GATE_RST;
        end else begin
            st_q <= st_d;
        end
    end

    pit_out_decode u_dec (
        .mode  (st_q.mode),
        .cnt   (st_q.cnt),
        .elap  (st_q.elap),
        .phase (st_q.phase),
        .out   (out)
    );

    // R1: a load restarts the tick reference
    a_r1_load_restart: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (st_q.elap == '0) && (st_q.phase == '0));

    // R8: the effective count is never zero
    a_r8_cnt_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt != '0);

    // R5: the position inside a period stays below the count
    a_r5_phase_in_period: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.phase < st_q.cnt);

    // R2: the terminal flag stays high until a reload
    a_r2_term_latched: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.mode == M_TERM && out && !load) |=> out);

    // R6: an open-gated strobe lasts one tick
    a_r6_strobe_single: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.mode == M_SWSTB || st_q.mode == M_HWSTB) && out && st_q.gate && !load)
        |=> !out);

    // R10: a closed gate freezes counting
    a_r10_gate_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.gate && !load) |=> ($stable(st_q.elap) && $stable(st_q.phase)));
endmodule

// File: rtl/pit_timer.sv
module pit_timer
    import pit_pkg::*;
#(
    parameter int              CH_N     = 3,
    parameter logic [CH_N-1:0] GATE_RST = 3'b011
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [CH_N-1:0]         load,
    input  logic [MODE_W*CH_N-1:0]  mode_in,
    input  logic [CNT_W*CH_N-1:0]   count_in,
    input  logic [CH_N-1:0]         gate_wr,
    input  logic [CH_N-1:0]         gate_val,
    output logic [CH_N-1:0]         out
);
    for (genvar i = 0; i < CH_N; i++) begin : g_ch
        pit_channel #(.GATE_RST(GATE_RST[i])) u_ch (
            .clk      (clk),
            .rst_n    (rst_n),
            .load     (load[i]),
            .mode_in  (mode_in[i*MODE_W +: MODE_W]),
            .count_in (count_in[i*CNT_W +: CNT_W]),
            .gate_wr  (gate_wr[i]),
            .gate_val (gate_val[i]),
            .out      (out[i])
        );
    end
endmodule

// File: tb/pit_timer_tb_top.sv
`timescale 1ns/100ps
module pit_timer_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  load = '0;
    logic [8:0]  mode_in = '0;
    logic [47:0] count_in = '0;
    logic [2:0]  gate_wr = '0;
    logic [2:0]  gate_val = '0;
    logic [2:0]  out;

    int    n_chk = 0;
    int    n_fail = 0;
    string cur_tag = "R9";

    int     m_mode [3];
    longint m_cnt  [3];
    longint m_d    [3];
    bit     m_gate [3];

    always #2.5 clk = ~clk;

    pit_timer dut_i (
        .clk(clk), .rst_n(rst_n), .load(load), .mode_in(mode_in),
        .count_in(count_in), .gate_wr(gate_wr), .gate_val(gate_val), .out(out)
    );

    always @(posedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (!rst_n) begin
                m_mode[i] = 3;
                m_cnt[i]  = 65536;
                m_d[i]    = 0;
                m_gate[i] = (i != 2);
            end else begin
                bit g_old;
                g_old = m_gate[i];
                if (gate_wr[i]) m_gate[i] = gate_val[i];
                if (load[i]) begin
                    m_mode[i] = int'(mode_in[i*3 +: 3]);
                    m_cnt[i]  = (count_in[i*16 +: 16] == 16'd0) ? 65536
                                : longint'(count_in[i*16 +: 16]);
                    m_d[i]    = 0;
                end else if (g_old) begin
                    m_d[i] = m_d[i] + 1;
                end
            end
        end
    end

    function automatic bit exp_out(int i);
        int     m;
        longint c, d;
        m = (m_mode[i] > 5) ? 0 : m_mode[i];
        c = m_cnt[i];
        d = m_d[i];
        case (m)
            1:       return d < c;
            2:       return (d != 0) && (d % c == 0);
            3:       return (d % c) < ((c + 1) / 2);
            4, 5:    return d == c;
            default: return d >= c;
        endcase
    endfunction

    task automatic chk(bit act, bit exp, string tag, int ch);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s ch%0d t=%0t out=%0b expected=%0b", tag, ch, $time, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) begin
            @(negedge clk);
            for (int i = 0; i < 3; i++) chk(out[i], exp_out(i), cur_tag, i);
            load    = '0;
            gate_wr = '0;
        end
    endtask

    task automatic ld(int ch, int mode, int cnt);
        load[ch] = 1'b1;
        mode_in[ch*3 +: 3] = 3'(mode);
        count_in[ch*16 +: 16] = 16'(cnt);
    endtask

    task automatic gate(int ch, bit v);
        gate_wr[ch]  = 1'b1;
        gate_val[ch] = v;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(out[0], 1'b1, "R9", 0);
        chk(out[1], 1'b1, "R9", 1);
        chk(out[2], 1'b1, "R9", 2);
        cur_tag = "R9";
        tick(32780);
        chk(out[0], 1'b0, "R9", 0);
        chk(out[2], 1'b1, "R10", 2);

        cur_tag = "R2"; ld(0, 0, 5); tick(12);
        cur_tag = "R1"; ld(0, 0, 5); tick(3); ld(0, 0, 2); tick(5);
        ld(0, 1, 6); tick(2); ld(0, 1, 3); tick(6);
        cur_tag = "R3"; ld(0, 1, 4); tick(8);
        cur_tag = "R4"; ld(0, 2, 5); ld(1, 2, 3); tick(17);
        ld(0, 2, 1); tick(5);
        cur_tag = "R5"; ld(0, 3, 5); tick(16);
        ld(0, 3, 6); ld(1, 3, 3); tick(14);
        ld(0, 3, 2); tick(6); ld(0, 3, 1); tick(4);
        cur_tag = "R6"; ld(0, 4, 3); tick(8);
        ld(0, 5, 7); ld(1, 4, 1); tick(10);
        cur_tag = "R7"; ld(0, 6, 3); tick(6); ld(0, 7, 2); tick(6);
        cur_tag = "R10"; gate(2, 1'b1); ld(2, 3, 4); tick(6);
        gate(2, 1'b0); tick(5); ld(2, 0, 3); tick(4);
        gate(2, 1'b1); tick(6);
        cur_tag = "R8"; ld(0, 4, 0); ld(1, 3, 0); ld(2, 2, 0); tick(65545);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired, expected end of run");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule